// File: doc/BRIEF.md
# Board Reset and CPU Start Sequencer

This block walks an adapter board through its bring-up. A reset command first pulses the host bridge's soft-reset control. It then pulses the bridge's configuration-EEPROM reload control. Each pulse is followed by a settling gap. The sequence ends with the embedded CPU held in reset. A start command then releases the CPU in two steps. The first step applies the cold-reset mask alone. After a dwell, the warm-reset mask is added, and a longer dwell follows. Every wait is counted in milliseconds, and the length of a millisecond comes from a clocks-per-millisecond parameter, so simulation can use short waits.

A stop command quiesces the board in a fixed order. It parks the CPU, holds the line-interface and DSP in reset, disables the PCI interrupt, and finally forces the local interrupt request off. Stop acts only when it is addressed to controller 0. Each command is a single-cycle pulse. The block accepts a command only while it is idle, reports `busy` for the whole sequence, and raises `done` for one cycle at the end.

Top module: `board_boot_seq`

## Requirements
- R1: While `rstN` is low and after it is released, `bridgeSoftRst`=0, `eepromReload`=0, `cpuRstCtl`=2'b00, `lineDspRun`=1, `pciIrqEn`=1, `irqReqOff`=0, `busy`=0 and `done`=0.
- R2: A reset command sets `bridgeSoftRst` on the clock edge that samples the command. The bit stays high for SOFT_HOLD_MS x CLKS_PER_MS cycles and then stays low for a gap of SOFT_GAP_MS x CLKS_PER_MS cycles.
- R3: After that gap, `eepromReload` is high for RELOAD_HOLD_MS x CLKS_PER_MS cycles and then low for RELOAD_GAP_MS x CLKS_PER_MS cycles. It is never high together with `bridgeSoftRst`.
- R4: At the edge that ends the reload gap, `cpuRstCtl` is written to 2'b00 (CPU held in reset) and the reset sequence completes. Until then the word keeps its previous value.
- R5: The CPU control word uses bit 0 as the cold-reset mask and bit 1 as the warm-reset mask. A start command writes 2'b01 on the accepting edge and holds it for COLD_MS x CLKS_PER_MS cycles. It then writes 2'b11 and holds it for WARM_MS x CLKS_PER_MS cycles before completing. 2'b11 is only ever entered from 2'b01.
- R6: A stop command with `stopIdx`=0 does three things, each on its own edge. On the accepting edge it writes `cpuRstCtl`=2'b00 and `lineDspRun`=0. One cycle later it sets `pciIrqEn`=0. One cycle after that it sets `irqReqOff`=1 and completes. These three values hold until `rstN`.
- R7: A stop command with a non-zero `stopIdx` changes no output, and `busy` stays low.
- R8: `busy` is high from the accepting edge until the edge that completes the sequence. Any command that arrives while `busy` is high is dropped and does not alter the running sequence.
- R9: `done` is high for exactly one cycle. That cycle begins at the edge where `busy` falls.
- R10: When several commands arrive together while idle, reset wins over start, and start wins over stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdReset | input | 1 | One-cycle request for the bridge reset / EEPROM reload sequence |
| cmdStart | input | 1 | One-cycle request for the cold-then-warm CPU release |
| cmdStop | input | 1 | One-cycle request for the quiesce sequence |
| stopIdx | input | IDX_W | Controller index the stop request is aimed at |
| bridgeSoftRst | output | 1 | Bridge soft-reset control bit |
| eepromReload | output | 1 | Bridge configuration-EEPROM reload control bit |
| cpuRstCtl | output | 2 | CPU reset control word: bit 0 cold mask, bit 1 warm mask |
| lineDspRun | output | 1 | Line-interface/DSP run control, 0 holds them in reset |
| pciIrqEn | output | 1 | PCI interrupt enable |
| irqReqOff | output | 1 | Forces the local interrupt request off |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench probes the dwell boundaries cycle by cycle. A timer that restarts late or misses its prescaler reload would stretch or shorten a pulse by a cycle, and a check would catch that at the boundary. The bench injects commands at random points inside a running sequence. A design that accepts them would restart or switch the sequence, so the output pattern would break mid-run. It also sends stops with non-zero indices. If those are not filtered, the sticky interrupt and line controls are cleared early. Simultaneous commands check the priority order. A wrong order would run start or stop where reset is expected.

// File: rtl/board_seq_pkg.sv
package board_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_SOFT_HOLD,
    S_SOFT_GAP,
    S_LOAD_HOLD,
    S_LOAD_GAP,
    S_COLD,
    S_WARM,
    S_STOP_PCI,
    S_STOP_IRQ
  } seqState_t;

  typedef enum logic [2:0] {
    W_SOFT_HOLD,
    W_SOFT_GAP,
    W_LOAD_HOLD,
    W_LOAD_GAP,
    W_COLD,
    W_WARM
  } waitSel_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic       loadWait;
    waitSel_t   waitSel;
    logic       setSoft;
    logic       clrSoft;
    logic       setLoad;
    logic       clrLoad;
    logic       cpuWr;
    logic [1:0] cpuVal;
    logic       clrLine;
    logic       clrPci;
    logic       setIrqOff;
  } seqStrobe_t;

  localparam logic [1:0] CPU_HELD = 2'b00;
  localparam logic [1:0] CPU_COLD = 2'b01;
  localparam logic [1:0] CPU_BOTH = 2'b11;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/board_seq_timer.sv
module board_seq_timer
  #(parameter int CLKS_PER_MS = 125000,
    parameter int MS_W        = 4)
  (input  logic            clk,
   input  logic            rstN,
   input  logic            load,
   input  logic [MS_W-1:0] loadMs,
   output logic            expire);

  logic            running;
  logic [MS_W-1:0] msLeft;
  logic            msTick;

  generate
    if (CLKS_PER_MS <= 1) begin : g_noPre
      assign msTick = running;
    end else begin : g_pre
      localparam int PRE_W = $clog2(CLKS_PER_MS);
      localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(CLKS_PER_MS - 1);
      logic [PRE_W-1:0] preCnt;

      // prescaler restarts on every load so each dwell is exact
      always_ff @(posedge clk) begin
        if (!rstN)                       preCnt <= '0;
        else if (load || preCnt == '0)   preCnt <= PRE_TOP;
        else if (running)                preCnt <= preCnt - 1'b1;
      end

      assign msTick = running && (preCnt == '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      msLeft  <= '0;
    end else if (load) begin
      running <= 1'b1;
      msLeft  <= loadMs;
    end else if (msTick) begin
      msLeft <= msLeft - 1'b1;
      if (msLeft == MS_W'(1)) running <= 1'b0;
    end
  end

  assign expire = msTick && (msLeft == MS_W'(1));

endmodule

// File: rtl/board_seq_ctrl.sv
module board_seq_ctrl
  import board_seq_pkg::*;
  #(parameter int IDX_W = 2)
  (input  logic             clk,
   input  logic             rstN,
   input  logic             cmdReset,
   input  logic             cmdStart,
   input  logic             cmdStop,
   input  logic [IDX_W-1:0] stopIdx,
   input  logic             waitDone,
   output seqStrobe_t       stb,
   output logic             busy,
   output logic             done);

  seqState_t state, nextState;
  logic      doneNext;

  always_comb begin
    nextState = state;
    doneNext  = 1'b0;
    stb       = '0;
    stb.waitSel = W_SOFT_HOLD;
    unique case (state)
      S_IDLE: begin
        if (cmdReset) begin
          nextState    = S_SOFT_HOLD;
          stb.setSoft  = 1'b1;
          stb.loadWait = 1'b1;
          stb.waitSel  = W_SOFT_HOLD;
        end else if (cmdStart) begin
          nextState    = S_COLD;
          stb.cpuWr    = 1'b1;
          stb.cpuVal   = CPU_COLD;
          stb.loadWait = 1'b1;
          stb.waitSel  = W_COLD;
        end else if (cmdStop && stopIdx == '0) begin
          nextState   = S_STOP_PCI;
          stb.cpuWr   = 1'b1;
          stb.cpuVal  = CPU_HELD;
          stb.clrLine = 1'b1;
        end
      end
      S_SOFT_HOLD: if (waitDone) begin
        nextState    = S_SOFT_GAP;
        stb.clrSoft  = 1'b1;
        stb.loadWait = 1'b1;
        stb.waitSel  = W_SOFT_GAP;
      end
      S_SOFT_GAP: if (waitDone) begin
        nextState    = S_LOAD_HOLD;
        stb.setLoad  = 1'b1;
        stb.loadWait = 1'b1;
        stb.waitSel  = W_LOAD_HOLD;
      end
      S_LOAD_HOLD: if (waitDone) begin
        nextState    = S_LOAD_GAP;
        stb.clrLoad  = 1'b1;
        stb.loadWait = 1'b1;
        stb.waitSel  = W_LOAD_GAP;
      end
      S_LOAD_GAP: if (waitDone) begin
        nextState  = S_IDLE;
        stb.cpuWr  = 1'b1;
        stb.cpuVal = CPU_HELD;
        doneNext   = 1'b1;
      end
      S_COLD: if (waitDone) begin
        nextState    = S_WARM;
        stb.cpuWr    = 1'b1;
        stb.cpuVal   = CPU_BOTH;
        stb.loadWait = 1'b1;
        stb.waitSel  = W_WARM;
      end
      S_WARM: if (waitDone) begin
        nextState = S_IDLE;
        doneNext  = 1'b1;
      end
      S_STOP_PCI: begin
        nextState  = S_STOP_IRQ;
        stb.clrPci = 1'b1;
      end
      S_STOP_IRQ: begin
        nextState     = S_IDLE;
        stb.setIrqOff = 1'b1;
        doneNext      = 1'b1;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      done  <= doneNext;
    end
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/board_seq_dp.sv
module board_seq_dp
  import board_seq_pkg::*;
  #(parameter int CLKS_PER_MS    = 125000,
    parameter int MS_W           = 4,
    parameter int SOFT_HOLD_MS   = 1,
    parameter int SOFT_GAP_MS    = 1,
    parameter int RELOAD_HOLD_MS = 1,
    parameter int RELOAD_GAP_MS  = 1,
    parameter int COLD_MS        = 2,
    parameter int WARM_MS        = 10)
  (input  logic       clk,
   input  logic       rstN,
   input  seqStrobe_t stb,
   output logic       waitDone,
   output logic       bridgeSoftRst,
   output logic       eepromReload,
   output logic [1:0] cpuRstCtl,
   output logic       lineDspRun,
   output logic       pciIrqEn,
   output logic       irqReqOff);

  logic [MS_W-1:0] waitMs;

  always_comb begin
    unique case (stb.waitSel)
      W_SOFT_HOLD: waitMs = MS_W'(SOFT_HOLD_MS);
      W_SOFT_GAP:  waitMs = MS_W'(SOFT_GAP_MS);
      W_LOAD_HOLD: waitMs = MS_W'(RELOAD_HOLD_MS);
      W_LOAD_GAP:  waitMs = MS_W'(RELOAD_GAP_MS);
      W_COLD:      waitMs = MS_W'(COLD_MS);
      W_WARM:      waitMs = MS_W'(WARM_MS);
      default:     waitMs = MS_W'(1);
    endcase
  end

  board_seq_timer #(.CLKS_PER_MS(CLKS_PER_MS), .MS_W(MS_W)) timer_i (
    .clk    (clk),
    .rstN   (rstN),
    .load   (stb.loadWait),
    .loadMs (waitMs),
    .expire (waitDone));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bridgeSoftRst <= 1'b0;
      eepromReload  <= 1'b0;
      cpuRstCtl     <= CPU_HELD;
      lineDspRun    <= 1'b1;
      pciIrqEn      <= 1'b1;
      irqReqOff     <= 1'b0;
    end else begin
      if (stb.setSoft)        bridgeSoftRst <= 1'b1;
      else if (stb.clrSoft)   bridgeSoftRst <= 1'b0;
      if (stb.setLoad)        eepromReload  <= 1'b1;
      else if (stb.clrLoad)   eepromReload  <= 1'b0;
      if (stb.cpuWr)          cpuRstCtl     <= stb.cpuVal;
      if (stb.clrLine)        lineDspRun    <= 1'b0;
      if (stb.clrPci)         pciIrqEn      <= 1'b0;
      if (stb.setIrqOff)      irqReqOff     <= 1'b1;
    end
  end

endmodule

// File: rtl/board_boot_seq.sv
module board_boot_seq
  import board_seq_pkg::*;
  #(parameter int CLKS_PER_MS    = 125000,
    parameter int SOFT_HOLD_MS   = 1,
    parameter int SOFT_GAP_MS    = 1,
    parameter int RELOAD_HOLD_MS = 1,
    parameter int RELOAD_GAP_MS  = 1,
    parameter int COLD_MS        = 2,
    parameter int WARM_MS        = 10,
    parameter int IDX_W          = 2)
  (input  logic             clk,
   input  logic             rstN,
   input  logic             cmdReset,
   input  logic             cmdStart,
   input  logic             cmdStop,
   input  logic [IDX_W-1:0] stopIdx,
   output logic             bridgeSoftRst,
   output logic             eepromReload,
   output logic [1:0]       cpuRstCtl,
   output logic             lineDspRun,
   output logic             pciIrqEn,
   output logic             irqReqOff,
   output logic             busy,
   output logic             done);

  localparam int MAX_MS = imax(imax(imax(SOFT_HOLD_MS, SOFT_GAP_MS),
                                    imax(RELOAD_HOLD_MS, RELOAD_GAP_MS)),
                               imax(COLD_MS, WARM_MS));
  localparam int MS_W = $clog2(MAX_MS + 1);

  seqStrobe_t stb;
  logic       waitDone;

  board_seq_ctrl #(.IDX_W(IDX_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cmdReset (cmdReset),
    .cmdStart (cmdStart),
    .cmdStop  (cmdStop),
    .stopIdx  (stopIdx),
    .waitDone (waitDone),
    .stb      (stb),
    .busy     (busy),
    .done     (done));

  board_seq_dp #(
    .CLKS_PER_MS    (CLKS_PER_MS),
    .MS_W           (MS_W),
    .SOFT_HOLD_MS   (SOFT_HOLD_MS),
    .SOFT_GAP_MS    (SOFT_GAP_MS),
    .RELOAD_HOLD_MS (RELOAD_HOLD_MS),
    .RELOAD_GAP_MS  (RELOAD_GAP_MS),
    .COLD_MS        (COLD_MS),
    .WARM_MS        (WARM_MS)) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .waitDone      (waitDone),
    .bridgeSoftRst (bridgeSoftRst),
    .eepromReload  (eepromReload),
    .cpuRstCtl     (cpuRstCtl),
    .lineDspRun    (lineDspRun),
    .pciIrqEn      (pciIrqEn),
    .irqReqOff     (irqReqOff));

endmodule

// File: rtl/board_boot_seq_chk.sv
module board_boot_seq_chk
  #(parameter int IDX_W = 2)
  (input logic             clk,
   input logic             rstN,
   input logic             cmdReset,
   input logic             cmdStart,
   input logic             cmdStop,
   input logic [IDX_W-1:0] stopIdx,
   input logic             bridgeSoftRst,
   input logic             eepromReload,
   input logic [1:0]       cpuRstCtl,
   input logic             lineDspRun,
   input logic             pciIrqEn,
   input logic             irqReqOff,
   input logic             busy,
   input logic             done);

  // R3: reload and soft reset never overlap
  p_soft_load_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(bridgeSoftRst && eepromReload));

  // R2: bridge controls only move inside a sequence
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!bridgeSoftRst && !eepromReload));

  // R5: warm mask only added on top of cold
  p_warm_after_cold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRstCtl == 2'b11 && $past(cpuRstCtl) != 2'b11) |-> ($past(cpuRstCtl) == 2'b01));

  // R6: quiesced controls are sticky
  p_irq_off_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqReqOff |=> irqReqOff);
  p_pci_off_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    !pciIrqEn |=> !pciIrqEn);
  p_line_off_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    !lineDspRun |=> !lineDspRun);

  // R7: stop to another controller leaves block idle
  p_stop_other_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdStop && stopIdx != '0 && !cmdReset && !cmdStart) |=> !busy);

  // R9: single-cycle done aligned with busy falling
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

endmodule

bind board_boot_seq board_boot_seq_chk #(.IDX_W(IDX_W)) chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .cmdReset      (cmdReset),
  .cmdStart      (cmdStart),
  .cmdStop       (cmdStop),
  .stopIdx       (stopIdx),
  .bridgeSoftRst (bridgeSoftRst),
  .eepromReload  (eepromReload),
  .cpuRstCtl     (cpuRstCtl),
  .lineDspRun    (lineDspRun),
  .pciIrqEn      (pciIrqEn),
  .irqReqOff     (irqReqOff),
  .busy          (busy),
  .done          (done));

// File: tb/board_boot_seq_tb_top.sv
module board_boot_seq_tb_top;

  localparam int CPM   = 4;
  localparam int IDX_W = 2;
  localparam int SH = 1, SG = 1, RH = 1, RG = 1, CM = 2, WM = 10;
  localparam int RESET_LEN = (SH + SG + RH + RG) * CPM;
  localparam int START_LEN = (CM + WM) * CPM;
  localparam int STOP_LEN  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdReset = 1'b0, cmdStart = 1'b0, cmdStop = 1'b0;
  logic [IDX_W-1:0] stopIdx = '0;
  logic bridgeSoftRst, eepromReload, lineDspRun, pciIrqEn, irqReqOff, busy, done;
  logic [1:0] cpuRstCtl;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  int expCpu = 0, expLine = 1, expPci = 1, expIrq = 0;

  always #4 clk = ~clk;

  board_boot_seq #(
    .CLKS_PER_MS(CPM), .SOFT_HOLD_MS(SH), .SOFT_GAP_MS(SG),
    .RELOAD_HOLD_MS(RH), .RELOAD_GAP_MS(RG), .COLD_MS(CM), .WARM_MS(WM),
    .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rstN(rstN), .cmdReset(cmdReset), .cmdStart(cmdStart),
    .cmdStop(cmdStop), .stopIdx(stopIdx), .bridgeSoftRst(bridgeSoftRst),
    .eepromReload(eepromReload), .cpuRstCtl(cpuRstCtl), .lineDspRun(lineDspRun),
    .pciIrqEn(pciIrqEn), .irqReqOff(irqReqOff), .busy(busy), .done(done));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nFails = nFails + 1;
      $display("FAIL watchdog: got %0d cycles expected below 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // expected values per cycle offset j after the accepting edge
  function automatic int expSoft(input int kind, input int j);
    return (kind == 0 && j < SH * CPM) ? 1 : 0;
  endfunction
  function automatic int expLoad(input int kind, input int j);
    return (kind == 0 && j >= (SH + SG) * CPM && j < (SH + SG + RH) * CPM) ? 1 : 0;
  endfunction
  function automatic int seqLen(input int kind);
    return (kind == 0) ? RESET_LEN : (kind == 1) ? START_LEN : STOP_LEN;
  endfunction
  function automatic int expCpuAt(input int kind, input int j, input int prev);
    if (kind == 0) return (j < RESET_LEN) ? prev : 0;
    if (kind == 1) return (j < CM * CPM) ? 1 : 3;
    return 0;
  endfunction

  task automatic chkIdle(input string req);
    chk(req, "soft", int'(bridgeSoftRst), 0);
    chk(req, "reload", int'(eepromReload), 0);
    chk(req, "cpu", int'(cpuRstCtl), expCpu);
    chk(req, "line", int'(lineDspRun), expLine);
    chk(req, "pci", int'(pciIrqEn), expPci);
    chk(req, "irqOff", int'(irqReqOff), expIrq);
    chk(req, "busy", int'(busy), 0);
    chk(req, "done", int'(done), 0);
  endtask

  task automatic setCmd(input int kind, input int idx);
    cmdReset = (kind == 0);
    cmdStart = (kind == 1);
    cmdStop  = (kind == 2 || kind == 3);
    stopIdx  = IDX_W'(idx);
  endtask

  task automatic clrCmd();
    cmdReset = 1'b0; cmdStart = 1'b0; cmdStop = 1'b0; stopIdx = '0;
  endtask

  // runs the checks of a sequence of kind (0 reset,1 start,2 stop idx0);
  // command already sampled; we stand at the sample point j=0
  task automatic checkSeq(input int kind, input int injAt, input int injKind);
    int len = seqLen(kind);
    string rq;
    for (int j = 0; j <= len; j++) begin
      chk("R2", "soft", int'(bridgeSoftRst), expSoft(kind, j));
      chk("R3", "reload", int'(eepromReload), expLoad(kind, j));
      rq = (kind == 0) ? "R4" : (kind == 1) ? "R5" : "R6";
      chk(rq, "cpu", int'(cpuRstCtl), expCpuAt(kind, j, expCpu));
      if (kind == 2) begin
        chk("R6", "line", int'(lineDspRun), 0);
        chk("R6", "pci", int'(pciIrqEn), (j >= 1) ? 0 : expPci);
        chk("R6", "irqOff", int'(irqReqOff), (j >= 2) ? 1 : expIrq);
      end else begin
        chk("R8", "line", int'(lineDspRun), expLine);
        chk("R8", "pci", int'(pciIrqEn), expPci);
        chk("R8", "irqOff", int'(irqReqOff), expIrq);
      end
      chk("R8", "busy", int'(busy), (j < len) ? 1 : 0);
      chk("R9", "done", int'(done), (j == len) ? 1 : 0);
      clrCmd();
      if (j == injAt) setCmd(injKind, 0);
      @(negedge clk);
    end
    expCpu = expCpuAt(kind, len, expCpu);
    if (kind == 2) begin expLine = 0; expPci = 0; expIrq = 1; end
    chk("R9", "done after pulse", int'(done), 0);
  endtask

  task automatic issue(input int kind, input int idx);
    setCmd(kind, idx);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    chkIdle("R1");
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkIdle("R1");

    // R10: all three together -> reset sequence
    cmdReset = 1'b1; cmdStart = 1'b1; cmdStop = 1'b1; stopIdx = '0;
    @(negedge clk);
    checkSeq(0, -1, 0);

    // R5: cold then warm
    issue(1, 0);
    checkSeq(1, -1, 0);

    // R7: stop to other controllers ignored
    for (int k = 1; k < 4; k++) begin
      issue(3, k);
      clrCmd();
      for (int c = 0; c < 3; c++) begin
        chkIdle("R7");
        @(negedge clk);
      end
    end

    // R10: start and stop together -> start
    cmdStart = 1'b1; cmdStop = 1'b1; stopIdx = '0;
    @(negedge clk);
    checkSeq(1, -1, 0);

    // R8: commands dropped while busy, incl. last busy cycle
    issue(0, 0);
    checkSeq(0, RESET_LEN - 1, 1);
    issue(1, 0);
    checkSeq(1, 3, 0);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int op  = int'($urandom % 4);
      int inj = -1;
      int ik  = int'($urandom % 3);
      int gap = int'($urandom % 4);
      if (op == 3) begin
        issue(3, 1 + int'($urandom % 3));
        clrCmd();
        chkIdle("R7");
        @(negedge clk);
      end else begin
        if ($urandom % 2 == 0) inj = int'($urandom % seqLen(op));
        issue(op, 0);
        checkSeq(op, inj, ik);
      end
      for (int g = 0; g < gap; g++) @(negedge clk);
    end

    // R6 directed at end (sticky values tracked by model)
    issue(2, 0);
    checkSeq(2, 0, 1);
    chkIdle("R6");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule